// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware side of taking an interrupt on a small 8-bit microcontroller core. It keeps a register of pending interrupt sources, which peripherals set through a set-strobe vector. It also watches a reset-request line and the core's global interrupt-enable flag. When entry is allowed and something is waiting, it accepts the request. It captures the current program counter and stack pointer, and picks the winning source.

It then writes the return address to a byte-wide stack, one byte per cycle, through a write-only memory port. The cycle after the last stack write it raises a one-cycle completion pulse. In that cycle the core loads the new program counter and the new stack pointer, and clears its global enable flag.

Parameters set the program-counter width in bytes (1 to 3), the vector slot size (one or two words), the vector base address and the number of sources.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_we_o` are 0 and `pend_o` is all zeros.
- R2: No entry is accepted while `gie_i` is 0. This holds even with pending bits set or `rst_req_i` high: `busy_o` stays 0, no stack write occurs and `pend_o` is unchanged.
- R3: A high `rst_req_i` takes priority over pending sources. Its entry reports vector number 0 on `vec_o`, and the pending register is left unchanged.
- R4: For a hardware entry, the winning source is the lowest-indexed set bit of `pend_o`. `vec_o` reports that index plus one.
- R5: On acceptance of a hardware entry, only the winning pending bit is cleared. All other bits keep their value.
- R6: Starting the cycle after acceptance, exactly PC_BYTES single-cycle writes occur on consecutive cycles. Write k (k = 0, 1, 2) carries bits [8k+7:8k] of the captured program counter, so the least significant byte goes first. Its address is the captured stack pointer minus k.
- R7: During `done_o`, `pc_new_o` equals VEC_BASE + `vec_o` × slot. The slot is 2 when LONG_VEC is 1 and 1 otherwise. `sp_new_o` equals the captured stack pointer minus PC_BYTES.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last stack write. It tells the core to load `pc_new_o` and `sp_new_o` and to clear its global enable flag.
- R9: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. Requests present during that time start no second entry and cause no extra writes.
- R10: A 1 on bit i of `src_set_i` sets pending bit i at the next edge. If that bit is cleared as the winner at the same edge, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie_i | input | 1 | Global interrupt-enable flag from the core |
| rst_req_i | input | 1 | Reset-vector request (level) |
| src_set_i | input | NUM_SRC | Per-source pending set strobes |
| pc_i | input | 8*PC_BYTES | Current program counter (word address) |
| sp_i | input | SP_W | Current stack pointer |
| pend_o | output | NUM_SRC | Pending source register |
| busy_o | output | 1 | Entry in progress |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | SP_W | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| done_o | output | 1 | Entry complete: load PC and SP, clear enable flag |
| vec_o | output | $clog2(NUM_SRC+1) | Vector number of the current entry |
| pc_new_o | output | 8*PC_BYTES | Vector address to load |
| sp_new_o | output | SP_W | Stack pointer after the pushes |

## Verification
The hardest case to reach from the ports is a pending bit being set by a peripheral at the same edge at which it is cleared as the winner. The bench first builds up a pending pattern with set strobes alone. It then raises `gie_i` and drives a set strobe on the expected winner in the very cycle before the accepting edge. Requests that arrive while an entry is underway are covered the same way: `gie_i` is held high and a new source strobe is injected mid-push. The bench then checks that the write count and the final pending pattern are exact.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NUM_SRC  = 8,
  parameter int PC_BYTES = 3,
  parameter int LONG_VEC = 1,
  parameter int VEC_BASE = 0,
  parameter int SP_W     = 16,
  localparam int PCW = 8 * PC_BYTES,
  localparam int VW  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gie_i,
  input  logic               rst_req_i,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [PCW-1:0]     pc_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               done_o,
  output logic [VW-1:0]      vec_o,
  output logic [PCW-1:0]     pc_new_o,
  output logic [SP_W-1:0]    sp_new_o
);
  localparam int SLOT = (LONG_VEC != 0) ? 2 : 1;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_DONE} st_t;

  st_t                st_q;
  logic [1:0]         cnt_q;
  logic [SP_W-1:0]    sp_q;
  logic [PCW-1:0]     pc_q;
  logic [VW-1:0]      vec_q;
  logic [NUM_SRC-1:0] pend_q;

  logic [VW-1:0]      win_idx;
  logic               any_pend;
  logic               accept;
  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_q[i]) win_idx = VW'(i);
  end

  assign any_pend = |pend_q;
  assign accept   = (st_q == S_IDLE) && gie_i && (rst_req_i || any_pend);
  assign clr_mask = (accept && !rst_req_i) ? (NUM_SRC'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
      vec_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | src_set_i;
      case (st_q)
        S_IDLE: if (accept) begin
          st_q  <= S_PUSH;
          cnt_q <= '0;
          sp_q  <= sp_i;
          pc_q  <= pc_i;
          vec_q <= rst_req_i ? '0 : VW'(win_idx + 1'b1);
        end
        S_PUSH: begin
          sp_q  <= sp_q - 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 2'(PC_BYTES - 1)) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign pend_o      = pend_q;
  assign busy_o      = (st_q != S_IDLE);
  assign mem_we_o    = (st_q == S_PUSH);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = 8'(pc_q >> {cnt_q, 3'b000});
  assign done_o      = (st_q == S_DONE);
  assign vec_o       = vec_q;
  assign pc_new_o    = PCW'(VEC_BASE + int'(vec_q) * SLOT);
  assign sp_new_o    = sp_q;
endmodule

module irq_entry_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gie_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_we_o,
  input logic [SP_W-1:0] mem_addr_o,
  input logic [SP_W-1:0] sp_new_o
);
  a_r2_entry_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(gie_i));
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) - 1'b1);
  a_r7_sp_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_o) |-> sp_new_o == $past(mem_addr_o) - 1'b1);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_we_o));
  a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
endmodule

bind irq_entry_seq irq_entry_chk #(.SP_W(SP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .busy_o(busy_o), .done_o(done_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .sp_new_o(sp_new_o)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic        gie = 0, rst_req = 0;
  logic [7:0]  src_set = 0;
  logic [23:0] pc_i = 0;
  logic [15:0] sp_i = 0;
  logic [7:0]  pend;
  logic        busy, we, done;
  logic [15:0] addr, sp_new;
  logic [7:0]  wdata;
  logic [3:0]  vec;
  logic [23:0] pc_new;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .gie_i(gie), .rst_req_i(rst_req), .src_set_i(src_set),
    .pc_i(pc_i), .sp_i(sp_i), .pend_o(pend), .busy_o(busy), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .done_o(done), .vec_o(vec),
    .pc_new_o(pc_new), .sp_new_o(sp_new));

  logic       b_gie = 0, b_rst_req = 0;
  logic [3:0] b_set = 0;
  logic [7:0] b_pc = 0;
  logic [7:0] b_sp = 0;
  logic [3:0] b_pend;
  logic       b_busy, b_we, b_done;
  logic [7:0] b_addr, b_wdata, b_pc_new, b_sp_new;
  logic [2:0] b_vec;

  irq_entry_seq #(.NUM_SRC(4), .PC_BYTES(1), .LONG_VEC(0), .VEC_BASE(16), .SP_W(8)) dut1_i (
    .clk(clk), .rst_n(rst_n), .gie_i(b_gie), .rst_req_i(b_rst_req), .src_set_i(b_set),
    .pc_i(b_pc), .sp_i(b_sp), .pend_o(b_pend), .busy_o(b_busy), .mem_we_o(b_we),
    .mem_addr_o(b_addr), .mem_wdata_o(b_wdata), .done_o(b_done), .vec_o(b_vec),
    .pc_new_o(b_pc_new), .sp_new_o(b_sp_new));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic set_src(input logic [7:0] m);
    src_set = m; tick(); src_set = 0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 we", we, 0);     chk("R1 pend", pend, 0);
  endtask

  task automatic t_gie_off;
    set_src(8'h60);
    rst_req = 1; gie = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 busy", busy, 0); chk("R2 we", we, 0);
    end
    chk("R2 pend", pend, 8'h60);
    rst_req = 0;
  endtask

  task automatic entry(input logic [23:0] pc, input logic [15:0] sp, input logic rst,
                       input logic [7:0] set_at, input logic [7:0] mid,
                       input logic [3:0] evec, input logic [7:0] epend,
                       input logic [7:0] efinal, input string tag);
    gie = 1; rst_req = rst; pc_i = pc; sp_i = sp; src_set = set_at;
    tick();
    src_set = 0;
    chk({tag, " R9 busy"}, busy, 1);
    chk({tag, " R5 pend"}, pend, epend);
    for (int b = 0; b < 3; b++) begin
      chk({tag, " R6 we"}, we, 1);
      chk({tag, " R6 addr"}, addr, sp - 16'(b));
      chk({tag, " R6 data"}, wdata, 8'(pc >> (8 * b)));
      src_set = (b == 0) ? mid : 8'h00;
      tick();
    end
    src_set = 0;
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " R9 no extra write"}, we, 0);
    chk({tag, " R4 vec"}, vec, evec);
    chk({tag, " R7 pc"}, pc_new, 24'(evec) * 2);
    chk({tag, " R7 sp"}, sp_new, sp - 16'd3);
    gie = 0; rst_req = 0;
    tick();
    chk({tag, " R8 done pulse"}, done, 0);
    chk({tag, " R9 busy end"}, busy, 0);
    chk({tag, " R10 pend"}, pend, efinal);
  endtask

  task automatic t_narrow;
    b_set = 4'hA; tick(); b_set = 0;
    b_gie = 1; b_pc = 8'h5C; b_sp = 8'h40;
    tick();
    chk("N R5 pend", b_pend, 4'h8);
    chk("N R6 we", b_we, 1); chk("N R6 addr", b_addr, 8'h40); chk("N R6 data", b_wdata, 8'h5C);
    tick();
    chk("N R8 done", b_done, 1); chk("N R4 vec", b_vec, 2);
    chk("N R7 pc", b_pc_new, 8'd18); chk("N R7 sp", b_sp_new, 8'h3F);
    b_gie = 0;
    tick();
    chk("N R9 idle", b_busy, 0); chk("N R6 we", b_we, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_gie_off();
    entry(24'h123456, 16'h0200, 1, 8'h00, 8'h00, 4'd0, 8'h60, 8'h60, "R3 reset first");
    set_src(8'h04);
    entry(24'hABCDEF, 16'h01F0, 0, 8'h00, 8'h01, 4'd3, 8'h60, 8'h61, "R4 lowest");
    entry(24'h00F00D, 16'h0100, 0, 8'h01, 8'h00, 4'd1, 8'h61, 8'h61, "R10 set wins");
    entry(24'h000102, 16'h0080, 0, 8'h00, 8'h00, 4'd1, 8'h60, 8'h60, "R5 clear one");
    entry(24'h7F8081, 16'hFFFF, 0, 8'h00, 8'h00, 4'd6, 8'h40, 8'h40, "R4 high bit");
    t_narrow();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule